// File: doc/BRIEF.md
# Power-Management Register Slave with Interrupt Controller

This block is a bank of 32 sixteen-bit registers that sits behind the parallel side of a three-wire serial bus target. Each access arrives as a register index with a valid flag, a write flag and write data. The block drives its read data combinationally in the same cycle, and it commits writes on the clock edge. It keeps an interrupt status word with a mask and drives a level interrupt line. It also provides the following:

- an ADC readback selected by channel, where each channel's result is a fixed value computed from its channel number;
- a sample-control word whose bits are cleared by writing ones;
- a calibration register and two general control words;
- an identity word that carries a variant flag;
- a key-status word that follows an asynchronous power-key pin;
- a watchdog register that can request a system shutdown.

Interrupt status bits have these meanings: 0 power key, 1 charger, 2 seconds tick, 3 minutes tick, 4 days tick, 5 alarm, 6 hook, 7 headset, 8 ADC sample. Only bits 0 and 8 have internal sources in this block.

Top module: `pmic_reg_slave`

## Requirements
- R1: After reset the mask (0x02) reads 0xFFFF, interrupt status (0x01) reads 0x0000, calibration (0x06) reads 0x0001, and irqOut, shutdownReq and badReg are low.
- R2: irqOut is high exactly when some interrupt status bit is 1 while the same mask bit is 0. A mask bit of 1 disables that source.
- R3: A write to 0x01 XORs the write data into the interrupt status, so writing a 1 toggles that bit. A read of 0x01 returns the raw status. Register 0x02 is a read/write mask.
- R4: A read of 0x08 returns the selected channel in bits 13..10 and that channel's 10-bit result, (channel*67+5) mod 1024, in bits 9..0. A write to 0x08 takes the channel from bits 13..10 of the data, ignores the other bits, and sets interrupt status bit 8.
- R5: Register 0x09 resets to parameter SAMPLE_INIT (default 0x00FF). A write clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R6: Register 0x00 reads 0x0215, with bit 7 also set while variantIn is high.
- R7: A write of 0x0000 to 0x17 while bit 1 of 0x0D is set raises shutdownReq for exactly the one cycle after the write edge. Any other value written to 0x17, or a write made while bit 1 of 0x0D is clear, raises nothing.
- R8: keyIn (1 = pressed) passes through a two-stage synchronizer. Each change of the synchronized level sets interrupt status bit 0. Register 0x16 reads 0x0020 while the key is released and 0x0000 while it is pressed.
- R9: Registers 0x06, 0x0D and 0x0E are plain read/write 16-bit registers.
- R10: Indices 0x03-0x05, 0x0A-0x0C, 0x0F-0x11, 0x17 and 0x18-0x1F read as zero and ignore writes. Registers 0x00 and 0x16 ignore writes.
- R11: Indices 0x07 and 0x12-0x15 read as zero and ignore writes. Any access to them raises badReg for the one cycle after the access edge.
- R12: regRdata is zero in any cycle that is not a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Access strobe for this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regIdx | input | 5 | Register index |
| regWdata | input | 16 | Write data |
| keyIn | input | 1 | Asynchronous power-key level, 1 = pressed |
| variantIn | input | 1 | Variant flag shown in the identity word |
| regRdata | output | 16 | Read data, combinational |
| irqOut | output | 1 | Level interrupt |
| shutdownReq | output | 1 | One-cycle shutdown request |
| badReg | output | 1 | One-cycle flag for an access to an undefined index |

## Verification
The bench first writes a 1 to an interrupt status bit that is already set, to check that the bit toggles. A design that cleared or set status on a write would read back the wrong word. It writes the ADC register with every bit high, so a design that took the channel from the wrong field, or failed to drop the bits outside it, would return a different channel and result. The watchdog is written with zero both while the enable bit is clear and while it is set, then with a nonzero value. This exposes an ungated or stretched shutdown pulse. Writes to read-only, zero-only and undefined indices are each read back, so a design that stored them, or that raised the error flag for defined indices, would be caught.

// File: rtl/pmic_reg_pkg.sv
package pmic_reg_pkg;
  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IDX_ID     = 5'h00;
  localparam logic [IDX_W-1:0] IDX_IRQ    = 5'h01;
  localparam logic [IDX_W-1:0] IDX_MASK   = 5'h02;
  localparam logic [IDX_W-1:0] IDX_CAL    = 5'h06;
  localparam logic [IDX_W-1:0] IDX_ADC    = 5'h08;
  localparam logic [IDX_W-1:0] IDX_SAMPLE = 5'h09;
  localparam logic [IDX_W-1:0] IDX_CTL1   = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_CTL2   = 5'h0E;
  localparam logic [IDX_W-1:0] IDX_KEY    = 5'h16;
  localparam logic [IDX_W-1:0] IDX_WDOG   = 5'h17;

  localparam int IRQ_KEY_BIT = 0;
  localparam int IRQ_ADC_BIT = 8;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ID, RD_IRQ, RD_MASK, RD_CAL, RD_ADC,
    RD_SAMPLE, RD_CTL1, RD_CTL2, RD_KEY
  } rdSel_e;

  typedef struct packed {
    logic wrIrqXor;
    logic wrMask;
    logic wrCal;
    logic wrAdc;
    logic wrSample;
    logic wrCtl1;
    logic wrCtl2;
    logic wrWdog;
  } wrStrobe_t;
endpackage

// File: rtl/pmic_reg_ctrl.sv
module pmic_reg_ctrl
  import pmic_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [IDX_W-1:0] regIdx,
  output wrStrobe_t        wr,
  output rdSel_e           rdSel,
  output logic             badReg
);
  logic   isBad;
  logic   doWrite;
  logic   doRead;
  rdSel_e idxSel;

  assign doWrite = regValid && regWrite;
  assign doRead  = regValid && !regWrite;

  // Index classification: which register a read selects, and whether the index is undefined.
  always_comb begin
    idxSel = RD_ZERO;
    isBad  = 1'b0;
    case (regIdx)
      IDX_ID:     idxSel = RD_ID;
      IDX_IRQ:    idxSel = RD_IRQ;
      IDX_MASK:   idxSel = RD_MASK;
      IDX_CAL:    idxSel = RD_CAL;
      IDX_ADC:    idxSel = RD_ADC;
      IDX_SAMPLE: idxSel = RD_SAMPLE;
      IDX_CTL1:   idxSel = RD_CTL1;
      IDX_CTL2:   idxSel = RD_CTL2;
      IDX_KEY:    idxSel = RD_KEY;
      5'h07, 5'h12, 5'h13, 5'h14, 5'h15: isBad = 1'b1;
      default:    idxSel = RD_ZERO;
    endcase
  end

  assign rdSel = doRead ? idxSel : RD_ZERO;  // R12

  always_comb begin
    wr          = '0;
    wr.wrIrqXor = doWrite && (regIdx == IDX_IRQ);
    wr.wrMask   = doWrite && (regIdx == IDX_MASK);
    wr.wrCal    = doWrite && (regIdx == IDX_CAL);
    wr.wrAdc    = doWrite && (regIdx == IDX_ADC);
    wr.wrSample = doWrite && (regIdx == IDX_SAMPLE);
    wr.wrCtl1   = doWrite && (regIdx == IDX_CTL1);
    wr.wrCtl2   = doWrite && (regIdx == IDX_CTL2);
    wr.wrWdog   = doWrite && (regIdx == IDX_WDOG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) badReg <= 1'b0;
    else       badReg <= regValid && isBad;  // R11
  end

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wr));

  p_bad_no_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    badReg |-> ($past(wr) == '0));
endmodule

// File: rtl/pmic_reg_datapath.sv
module pmic_reg_datapath
  import pmic_reg_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          CH_W        = 4,
  parameter int          RES_W       = 10,
  parameter int          CH_LSB      = 10,
  parameter int          ADC_STEP    = 67,
  parameter int          ADC_OFFS    = 5,
  parameter logic [15:0] ID_BASE     = 16'h0215,
  parameter int          VARIANT_BIT = 7,
  parameter int          SHUT_BIT    = 1,
  parameter int          KEY_BIT     = 5,
  parameter logic [15:0] SAMPLE_INIT = 16'h00FF,
  parameter logic [15:0] CAL_INIT    = 16'h0001
)(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wr,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              keyIn,
  input  logic              variantIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              shutdownReq
);
  localparam int CH_N = 1 << CH_W;

  logic [DATA_W-1:0] irqStatus, irqMask, calReg, ctl1Reg, ctl2Reg, sampleReg;
  logic [DATA_W-1:0] irqSet, irqNext;
  logic [CH_W-1:0]   adcChan;
  logic [RES_W-1:0]  adcTable [CH_N];
  logic              keyMeta, keySync, keyPrev, keyEdge;

  // Fixed per-channel conversion results.
  for (genvar c = 0; c < CH_N; c++) begin : g_adc
    assign adcTable[c] = RES_W'(c * ADC_STEP + ADC_OFFS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyMeta <= 1'b0;
      keySync <= 1'b0;
      keyPrev <= 1'b0;
    end else begin
      keyMeta <= keyIn;
      keySync <= keyMeta;
      keyPrev <= keySync;
    end
  end
  assign keyEdge = keySync ^ keyPrev;

  always_comb begin
    irqSet              = '0;
    irqSet[IRQ_KEY_BIT] = keyEdge;
    irqSet[IRQ_ADC_BIT] = wr.wrAdc;
    irqNext = (wr.wrIrqXor ? (irqStatus ^ wdata) : irqStatus) | irqSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStatus   <= '0;
      irqMask     <= '1;
      calReg      <= DATA_W'(CAL_INIT);
      ctl1Reg     <= '0;
      ctl2Reg     <= '0;
      sampleReg   <= DATA_W'(SAMPLE_INIT);
      adcChan     <= '0;
      shutdownReq <= 1'b0;
    end else begin
      irqStatus <= irqNext;
      if (wr.wrMask)   irqMask   <= wdata;
      if (wr.wrCal)    calReg    <= wdata;
      if (wr.wrCtl1)   ctl1Reg   <= wdata;
      if (wr.wrCtl2)   ctl2Reg   <= wdata;
      if (wr.wrSample) sampleReg <= sampleReg & ~wdata;
      if (wr.wrAdc)    adcChan   <= wdata[CH_LSB +: CH_W];
      shutdownReq <= wr.wrWdog && (wdata == '0) && ctl1Reg[SHUT_BIT];
    end
  end

  assign irqOut = |(irqStatus & ~irqMask);

  always_comb begin
    rdata = '0;
    case (rdSel)
      RD_ID:     rdata = DATA_W'(ID_BASE) | (DATA_W'(variantIn) << VARIANT_BIT);
      RD_IRQ:    rdata = irqStatus;
      RD_MASK:   rdata = irqMask;
      RD_CAL:    rdata = calReg;
      RD_ADC: begin
        rdata[CH_LSB +: CH_W] = adcChan;
        rdata[RES_W-1:0]      = adcTable[adcChan];
      end
      RD_SAMPLE: rdata = sampleReg;
      RD_CTL1:   rdata = ctl1Reg;
      RD_CTL2:   rdata = ctl2Reg;
      RD_KEY:    rdata[KEY_BIT] = ~keyPrev;
      default:   rdata = '0;
    endcase
  end

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask == '1) |-> !irqOut);

  p_xor_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wr.wrIrqXor && !keyEdge && !wr.wrAdc) |=> (irqStatus == $past(irqStatus ^ wdata)));

  p_adc_raises_r4: assert property (@(posedge clk) disable iff (!rstN)
    wr.wrAdc |=> irqStatus[IRQ_ADC_BIT]);

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rstN)
    wr.wrSample |=> ((sampleReg & $past(wdata)) == '0));

  p_shutdown_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !shutdownReq);

  p_key_sets_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    keyEdge |=> irqStatus[IRQ_KEY_BIT]);
endmodule

// File: rtl/pmic_reg_slave.sv
module pmic_reg_slave
  import pmic_reg_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter logic [15:0] SAMPLE_INIT = 16'h00FF
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              keyIn,
  input  logic              variantIn,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              shutdownReq,
  output logic              badReg
);
  wrStrobe_t wr;
  rdSel_e    rdSel;

  pmic_reg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regIdx   (regIdx),
    .wr       (wr),
    .rdSel    (rdSel),
    .badReg   (badReg)
  );

  pmic_reg_datapath #(
    .DATA_W      (DATA_W),
    .SAMPLE_INIT (SAMPLE_INIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wr          (wr),
    .rdSel       (rdSel),
    .wdata       (regWdata),
    .keyIn       (keyIn),
    .variantIn   (variantIn),
    .rdata       (regRdata),
    .irqOut      (irqOut),
    .shutdownReq (shutdownReq)
  );
endmodule

// File: tb/pmic_reg_slave_tb.sv
module pmic_reg_slave_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [4:0]  regIdx = '0;
  logic [15:0] regWdata = '0;
  logic        keyIn = 1'b0;
  logic        variantIn = 1'b0;
  logic [15:0] regRdata;
  logic        irqOut, shutdownReq, badReg;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lastRd;
  logic        lastShut, lastBad;

  always #10 clk = ~clk;  // 50 MHz

  pmic_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regIdx(regIdx), .regWdata(regWdata), .keyIn(keyIn), .variantIn(variantIn),
    .regRdata(regRdata), .irqOut(irqOut), .shutdownReq(shutdownReq), .badReg(badReg)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  idx;
    logic [15:0] data;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 16'h0000, 16'h0215, 8'd1},   // R1 id
    '{1'b0, 5'h02, 16'h0000, 16'hFFFF, 8'd1},   // R1 mask
    '{1'b0, 5'h01, 16'h0000, 16'h0000, 8'd1},   // R1 status
    '{1'b0, 5'h06, 16'h0000, 16'h0001, 8'd1},   // R1 cal
    '{1'b0, 5'h16, 16'h0000, 16'h0020, 8'd8},   // R8 released
    '{1'b0, 5'h09, 16'h0000, 16'h00FF, 8'd5},   // R5 reset
    '{1'b1, 5'h06, 16'hABCD, 16'h0000, 8'd9},
    '{1'b0, 5'h06, 16'h0000, 16'hABCD, 8'd9},   // R9
    '{1'b1, 5'h02, 16'h00FF, 16'h0000, 8'd3},
    '{1'b0, 5'h02, 16'h0000, 16'h00FF, 8'd3},   // R3 mask
    '{1'b1, 5'h01, 16'h0005, 16'h0000, 8'd3},
    '{1'b0, 5'h01, 16'h0000, 16'h0005, 8'd3},   // R3 xor
    '{1'b1, 5'h01, 16'h0004, 16'h0000, 8'd3},
    '{1'b0, 5'h01, 16'h0000, 16'h0001, 8'd3},   // R3 toggle off
    '{1'b1, 5'h0D, 16'h1234, 16'h0000, 8'd9},
    '{1'b0, 5'h0D, 16'h0000, 16'h1234, 8'd9},   // R9
    '{1'b1, 5'h0E, 16'h5678, 16'h0000, 8'd9},
    '{1'b0, 5'h0E, 16'h0000, 16'h5678, 8'd9},   // R9
    '{1'b1, 5'h09, 16'h000F, 16'h0000, 8'd5},
    '{1'b0, 5'h09, 16'h0000, 16'h00F0, 8'd5},   // R5 w1c
    '{1'b1, 5'h08, 16'h0C00, 16'h0000, 8'd4},
    '{1'b0, 5'h08, 16'h0000, 16'h0CCE, 8'd4},   // R4 ch3
    '{1'b0, 5'h01, 16'h0000, 16'h0101, 8'd4},   // R4 irq bit 8
    '{1'b1, 5'h08, 16'hFFFF, 16'h0000, 8'd4},
    '{1'b0, 5'h08, 16'h0000, 16'h3FF2, 8'd4},   // R4 ch15
    '{1'b1, 5'h05, 16'hFFFF, 16'h0000, 8'd10},
    '{1'b0, 5'h05, 16'h0000, 16'h0000, 8'd10},  // R10
    '{1'b1, 5'h16, 16'h0000, 16'h0000, 8'd10},
    '{1'b0, 5'h16, 16'h0000, 16'h0020, 8'd10},  // R10 ro
    '{1'b1, 5'h00, 16'hFFFF, 16'h0000, 8'd10},
    '{1'b0, 5'h00, 16'h0000, 16'h0215, 8'd10},  // R10 ro
    '{1'b1, 5'h07, 16'hFFFF, 16'h0000, 8'd11},
    '{1'b0, 5'h07, 16'h0000, 16'h0000, 8'd11},  // R11
    '{1'b0, 5'h14, 16'h0000, 16'h0000, 8'd11}   // R11
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample comb read data, commit at posedge, capture pulses at next negedge.
  task automatic access(input logic w, input logic [4:0] idx, input logic [15:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = w; regIdx = idx; regWdata = d;
    #2 lastRd = regRdata;
    @(posedge clk);
    @(negedge clk);
    lastShut = shutdownReq; lastBad = badReg;
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2;
    check("R1 irqOut", {15'd0, irqOut}, 16'd0);
    check("R1 shutdownReq", {15'd0, shutdownReq}, 16'd0);
    check("R1 badReg", {15'd0, badReg}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].idx, VECS[i].data);
      if (!VECS[i].wr) check($sformatf("R%0d idx %h", VECS[i].req, VECS[i].idx), lastRd, VECS[i].exp);
    end

    // R2: status 0x0101, mask 0x00FF
    #2 check("R2 bit8 unmasked", {15'd0, irqOut}, 16'd1);
    access(1'b1, 5'h02, 16'hFFFF);
    #2 check("R2 all masked", {15'd0, irqOut}, 16'd0);
    access(1'b1, 5'h02, 16'hFEFF);
    #2 check("R2 bit8 enabled", {15'd0, irqOut}, 16'd1);
    access(1'b1, 5'h01, 16'h0100);
    #2 check("R2 bit8 toggled off", {15'd0, irqOut}, 16'd0);
    access(1'b1, 5'h02, 16'hFFFE);
    #2 check("R2 bit0 enabled", {15'd0, irqOut}, 16'd1);
    access(1'b1, 5'h01, 16'h0001);
    #2 check("R2 status cleared", {15'd0, irqOut}, 16'd0);

    // R11 error flag, R12 read gating
    access(1'b1, 5'h12, 16'h1111);
    check("R11 bad write flag", {15'd0, lastBad}, 16'd1);
    access(1'b0, 5'h15, 16'h0000);
    check("R11 bad read flag", {15'd0, lastBad}, 16'd1);
    access(1'b0, 5'h06, 16'h0000);
    check("R11 good read no flag", {15'd0, lastBad}, 16'd0);
    @(negedge clk) regIdx = 5'h06; regValid = 1'b0;
    #2 check("R12 idle rdata", regRdata, 16'h0000);
    access(1'b1, 5'h06, 16'h7777);
    check("R12 write rdata", lastRd, 16'h0000);

    // R7 watchdog
    access(1'b1, 5'h17, 16'h0000);
    check("R7 no enable", {15'd0, lastShut}, 16'd0);
    access(1'b1, 5'h0D, 16'h0002);
    access(1'b1, 5'h17, 16'h0000);
    check("R7 shutdown pulse", {15'd0, lastShut}, 16'd1);
    idle(1);
    check("R7 pulse ends", {15'd0, shutdownReq}, 16'd0);
    access(1'b1, 5'h17, 16'h0001);
    check("R7 nonzero value", {15'd0, lastShut}, 16'd0);
    access(1'b0, 5'h17, 16'h0000);
    check("R10 wdog reads zero", lastRd, 16'h0000);

    // R8 power key
    keyIn = 1'b1;
    idle(5);
    access(1'b0, 5'h16, 16'h0000);
    check("R8 pressed status", lastRd, 16'h0000);
    access(1'b0, 5'h01, 16'h0000);
    check("R8 press irq", lastRd, 16'h0001);
    access(1'b1, 5'h01, 16'h0001);
    keyIn = 1'b0;
    idle(5);
    access(1'b0, 5'h16, 16'h0000);
    check("R8 released status", lastRd, 16'h0020);
    access(1'b0, 5'h01, 16'h0000);
    check("R8 release irq", lastRd, 16'h0001);

    // R6 variant
    variantIn = 1'b1;
    access(1'b0, 5'h00, 16'h0000);
    check("R6 variant id", lastRd, 16'h0295);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule